// File: doc/BRIEF.md
# Free-running timer capture/compare unit

This block is a timer for a microcontroller-style peripheral set. It has a counter that runs freely and advances once per cycle in which the tick enable is high. Two compare registers, A and B, raise event flags when the counter reaches their value. Compare A can optionally return the counter to zero. Four external capture inputs (A to D) are synchronized and edge-detected. On each edge, the counter value is latched into that channel's capture register. Channels C and D can instead act as history buffers for A and B. A write of zero to a flag in the status register clears it only if a read has first returned that flag as one. This keeps software from clearing an event it never saw.

The CPU reaches the block over an 8-bit register bus with an address, a read strobe, a write strobe and write/read data. Reads are combinational. The status register packs seven hardware-set flags and the clear-on-compare-A enable. An interrupt-enable register gates each flag onto its own interrupt request line. Asserting the standby input wipes the status register.

Top module: `ftmr_top`

## Requirements
- R1: After reset, the status register reads 0x00, all interrupt requests are low, the counter is 0, and the interrupt-enable and mode registers read 0x00.
- R2: The counter, CNT_W bits wide, increases by one on every cycle with tickEn high and holds its value otherwise. Going from all ones to zero while counting sets the overflow flag (status bit 1).
- R3: A tick taken while the counter equals compare A (or compare B) sets status bit 3 (or bit 2). The counter is compared with the low CNT_W bits of each compare register.
- R4: With status bit 0 set, a tick at a compare-A match loads the counter with zero instead of incrementing it. This load never sets the overflow flag, even when compare A is all ones.
- R5: Each capIn[i] goes through a two-flop synchronizer. Its rising edge copies the counter into capture register i and sets status bit 4+i. capIn[3] is channel A, [2] is B, [1] is C and [0] is D. The flag becomes visible three clock edges after the input rises.
- R6: Mode bit 0 buffers channel A and mode bit 1 buffers channel B. In buffered mode, an edge on A first moves the old capture A into capture C and then loads capture A (B pairs with D in the same way). Edges on the buffer channel itself are then ignored: no load and no flag.
- R7: Writing 1 to status bits 7..1 never sets them. Status bit 0 is an ordinary read/write bit.
- R8: A status flag is cleared by writing 0 to it only if a status read has returned it as 1 since the last status write. Any status write drops that permission for all bits.
- R9: If a flag's hardware set and its permitted software clear land in the same cycle, the flag stays set.
- R10: A cycle with standby high clears the whole status register, including bit 0, to 0x00.
- R11: irqReq[k] is high exactly while status bit k+1 and interrupt-enable bit k+1 are both 1. So irqReq[0] is overflow, irqReq[2] is compare A and irqReq[6] is capture A.
- R12: Register offsets: 0 status, 1 interrupt enable (bit 0 reads 0), 2 mode (bits 1..0), 3/4 compare A high/low, 5/6 compare B high/low, 8+2j/9+2j capture high/low for j=0..3 = A,B,C,D. Offset 7 reads 0. The compare registers reset to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Clears the status register while high |
| tickEn | input | 1 | Counter advance enable |
| capIn | input | 4 | Capture inputs, [3]=A .. [0]=D, asynchronous |
| busAddr | input | 4 | Register offset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| irqReq | output | 7 | Interrupt requests, one per status flag |

## Verification
The bench instantiates the block with CNT_W=10, which shortens a full counter period from 65536 ticks to 1024. At that width, wrap-around, the overflow flag, and a compare-A value equal to the counter's maximum are all reachable within a short run. The high byte of the compare and capture registers is still exercised, because the counter is wider than one bus byte. The counter is held with tickEn low whenever an edge is captured, so every captured value is a count the bench has tallied itself.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_CAP = 4;
  localparam int REG_W   = 16;
  localparam int NUM_FLG = 7;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CMPAH = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_CMPAL = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_CMPBH = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_CMPBL = 4'd6;

  // control -> datapath
  typedef struct packed {
    logic             cmpAHiWr;
    logic             cmpALoWr;
    logic             cmpBHiWr;
    logic             cmpBLoWr;
    logic [BUS_W-1:0] wrByte;
    logic             clrOnA;
    logic [1:0]       bufOn;   // [1]: A buffers into C, [0]: B buffers into D
  } tmrStrobes_t;

  // datapath -> control, packed to line up with status bits 7..1
  typedef struct packed {
    logic [NUM_CAP-1:0] cap;   // [3]=A .. [0]=D
    logic [1:0]         cmp;   // [1]=A, [0]=B
    logic               ovf;
  } tmrEvents_t;
endpackage

// File: rtl/ftmr_dpath.sv
module ftmr_dpath
  import ftmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tickEn,
  input  logic [NUM_CAP-1:0]           capIn,
  input  tmrStrobes_t                  strb,
  output tmrEvents_t                   ev,
  output logic [CNT_W-1:0]             cntQ,
  output logic [REG_W-1:0]             cmpAQ,
  output logic [REG_W-1:0]             cmpBQ,
  output logic [NUM_CAP-1:0][REG_W-1:0] capVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NUM_PAIR = NUM_CAP / 2;

  logic [NUM_CAP-1:0] syncA, syncB, syncC;
  logic [NUM_CAP-1:0] edgeDet;
  logic [REG_W-1:0]   cntWide;
  logic               matchA, matchB, wrapClr;

  assign cntWide = REG_W'(cntQ);
  assign matchA  = (cntQ == cmpAQ[CNT_W-1:0]);
  assign matchB  = (cntQ == cmpBQ[CNT_W-1:0]);
  assign wrapClr = strb.clrOnA && matchA;

  // input synchronizers and rising-edge detect, one chain per channel
  for (genvar ch = 0; ch < NUM_CAP; ch++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[ch] <= 1'b0;
        syncB[ch] <= 1'b0;
        syncC[ch] <= 1'b0;
      end else begin
        syncA[ch] <= capIn[ch];
        syncB[ch] <= syncA[ch];
        syncC[ch] <= syncB[ch];
      end
    end
    assign edgeDet[ch] = syncB[ch] & ~syncC[ch];
  end

  // counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntQ <= '0;
    else if (tickEn)
      cntQ <= wrapClr ? '0 : cntQ + 1'b1;
  end

  // compare registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpAQ <= '1;
      cmpBQ <= '1;
    end else begin
      if (strb.cmpAHiWr) cmpAQ[15:8] <= strb.wrByte;
      if (strb.cmpALoWr) cmpAQ[7:0]  <= strb.wrByte;
      if (strb.cmpBHiWr) cmpBQ[15:8] <= strb.wrByte;
      if (strb.cmpBLoWr) cmpBQ[7:0]  <= strb.wrByte;
    end
  end

  // capture pairs: lead channel (A or B) and its optional buffer (C or D)
  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    logic [REG_W-1:0] leadQ, folQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        leadQ <= '0;
        folQ  <= '0;
      end else begin
        if (edgeDet[k+NUM_PAIR]) begin
          leadQ <= cntWide;
          if (strb.bufOn[k]) folQ <= leadQ;
        end
        if (edgeDet[k] && !strb.bufOn[k]) folQ <= cntWide;
      end
    end
    assign capVal[k+NUM_PAIR] = leadQ;
    assign capVal[k]          = folQ;
  end

  assign ev.cap = edgeDet & ~{{NUM_PAIR{1'b0}}, strb.bufOn};
  assign ev.cmp = {tickEn & matchA, tickEn & matchB};
  assign ev.ovf = tickEn & (cntQ == CNT_MAX) & ~wrapClr;
endmodule

// File: rtl/ftmr_ctrl.sv
module ftmr_ctrl
  import ftmr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          standby,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          rdEn,
  input  logic                          wrEn,
  input  logic [BUS_W-1:0]              wrData,
  output logic [BUS_W-1:0]              rdData,
  input  tmrEvents_t                    ev,
  input  logic [REG_W-1:0]              cmpAQ,
  input  logic [REG_W-1:0]              cmpBQ,
  input  logic [NUM_CAP-1:0][REG_W-1:0] capVal,
  output tmrStrobes_t                   strb,
  output logic [BUS_W-1:0]              statQ,
  output logic [NUM_FLG-1:0]            armedQ,
  output logic [NUM_FLG-1:0]            irqReq
);
  logic [NUM_FLG-1:0] ienQ;
  logic [1:0]         modeQ;
  logic [NUM_FLG-1:0] evBits, clrMask;
  logic               wrStat, rdStat;
  logic [1:0]         capSel;
  logic [REG_W-1:0]   capWord;

  assign evBits  = ev;
  assign wrStat  = wrEn && (addr == OFS_STAT);
  assign rdStat  = rdEn && (addr == OFS_STAT);
  assign clrMask = wrStat ? (armedQ & ~wrData[7:1]) : '0;

  // status flags, clear-permission latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ  <= '0;
      armedQ <= '0;
    end else if (standby) begin
      statQ  <= '0;
      armedQ <= '0;
    end else begin
      statQ[7:1] <= (statQ[7:1] & ~clrMask) | evBits;
      if (wrStat) statQ[0] <= wrData[0];
      if (wrStat)      armedQ <= '0;
      else if (rdStat) armedQ <= armedQ | statQ[7:1];
    end
  end

  // enables and capture mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ  <= '0;
      modeQ <= '0;
    end else if (wrEn) begin
      if (addr == OFS_IEN)  ienQ  <= wrData[7:1];
      if (addr == OFS_MODE) modeQ <= wrData[1:0];
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrByte   = wrData;
    strb.clrOnA   = statQ[0];
    strb.bufOn    = {modeQ[0], modeQ[1]};
    strb.cmpAHiWr = wrEn && (addr == OFS_CMPAH);
    strb.cmpALoWr = wrEn && (addr == OFS_CMPAL);
    strb.cmpBHiWr = wrEn && (addr == OFS_CMPBH);
    strb.cmpBLoWr = wrEn && (addr == OFS_CMPBL);
  end

  // capture window: offset 8+2j high, 9+2j low, j=0 is channel A (index 3)
  assign capSel  = ~addr[2:1];
  assign capWord = capVal[capSel];

  always_comb begin
    rdData = '0;
    if (addr[3]) begin
      rdData = addr[0] ? capWord[7:0] : capWord[15:8];
    end else begin
      case (addr)
        OFS_STAT:  rdData = statQ;
        OFS_IEN:   rdData = {ienQ, 1'b0};
        OFS_MODE:  rdData = {6'b0, modeQ};
        OFS_CMPAH: rdData = cmpAQ[15:8];
        OFS_CMPAL: rdData = cmpAQ[7:0];
        OFS_CMPBH: rdData = cmpBQ[15:8];
        OFS_CMPBL: rdData = cmpBQ[7:0];
        default:   rdData = '0;
      endcase
    end
  end

  assign irqReq = statQ[7:1] & ienQ;
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
  import ftmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  standby,
  input  logic                  tickEn,
  input  logic [NUM_CAP-1:0]    capIn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [BUS_W-1:0]      busWrData,
  output logic [BUS_W-1:0]      busRdData,
  output logic [NUM_FLG-1:0]    irqReq
);
  tmrStrobes_t                   strbSig;
  tmrEvents_t                    evSig;
  logic [CNT_W-1:0]              cntQ;
  logic [REG_W-1:0]              cmpAQ, cmpBQ;
  logic [NUM_CAP-1:0][REG_W-1:0] capVal;
  logic [BUS_W-1:0]              statQ;
  logic [NUM_FLG-1:0]            armedQ;

  ftmr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .capIn  (capIn),
    .strb   (strbSig),
    .ev     (evSig),
    .cntQ   (cntQ),
    .cmpAQ  (cmpAQ),
    .cmpBQ  (cmpBQ),
    .capVal (capVal)
  );

  ftmr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .standby (standby),
    .addr    (busAddr),
    .rdEn    (busRd),
    .wrEn    (busWr),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .ev      (evSig),
    .cmpAQ   (cmpAQ),
    .cmpBQ   (cmpBQ),
    .capVal  (capVal),
    .strb    (strbSig),
    .statQ   (statQ),
    .armedQ  (armedQ),
    .irqReq  (irqReq)
  );
endmodule

// File: rtl/ftmr_checker.sv
module ftmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             standby,
  input logic             tickEn,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] cmpALo,
  input logic             clrOnA,
  input logic [6:0]       evBits,
  input logic [7:0]       statQ,
  input logic [6:0]       armedQ,
  input logic [6:0]       irqReq
);
  logic hitClr;
  assign hitClr = tickEn && clrOnA && (cntQ == cmpALo);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !hitClr) |=> (cntQ == CNT_W'($past(cntQ) + 1'b1)));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntQ));

  p_clear_on_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitClr |=> (cntQ == '0));

  p_no_ovf_from_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitClr |-> !evBits[0]);

  p_hw_only_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    !standby |=> ((statQ[7:1] & ~$past(statQ[7:1]) & ~$past(evBits)) == 7'd0));

  p_clear_needs_arm_r8: assert property (@(posedge clk) disable iff (!rstN)
    !standby |=> ((($past(statQ[7:1]) & ~statQ[7:1]) & ~$past(armedQ)) == 7'd0));

  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!standby && (evBits != 7'd0)) |=> ((statQ[7:1] & $past(evBits)) == $past(evBits)));

  p_standby_wipe_r10: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (statQ == 8'h00));

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~statQ[7:1]) == 7'd0);
endmodule

bind ftmr_top ftmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .standby (standby),
  .tickEn  (tickEn),
  .cntQ    (cntQ),
  .cmpALo  (cmpAQ[CNT_W-1:0]),
  .clrOnA  (strbSig.clrOnA),
  .evBits  (evSig),
  .statQ   (statQ),
  .armedQ  (armedQ),
  .irqReq  (irqReq)
);

// File: tb/sim_ftmr_top.sv
module sim_ftmr_top;
  localparam int CW   = 10;
  localparam int MODV = 1 << CW;

  logic       clk = 1'b0;
  logic       rstN;
  logic       standby;
  logic       tickEn;
  logic [3:0] capIn;
  logic [3:0] busAddr;
  logic       busRd;
  logic       busWr;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic [6:0] irqReq;

  int nErr = 0;
  int nChk = 0;
  int expCnt = 0;
  logic cclrExp = 1'b0;

  always #5 clk = ~clk;

  ftmr_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .standby(standby), .tickEn(tickEn), .capIn(capIn),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .irqReq(irqReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output int d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = int'(busRdData);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    expCnt = (expCnt + n) % MODV;
  endtask

  task automatic pulseCap(input int ch);
    @(negedge clk);
    capIn[ch] = 1'b1;
    repeat (4) @(negedge clk);
    capIn[ch] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readCap(input int ch, output int v);
    int hi, lo;
    busRead(4'(8 + 2 * (3 - ch)), hi);
    busRead(4'(9 + 2 * (3 - ch)), lo);
    v = (hi << 8) | lo;
  endtask

  task automatic writeCmp(input bit isA, input int v);
    busWrite(isA ? 4'd3 : 4'd5, 8'(v >> 8));
    busWrite(isA ? 4'd4 : 4'd6, 8'(v));
  endtask

  task automatic clearFlags();
    int s;
    busRead(4'd0, s);
    busWrite(4'd0, {7'b0, cclrExp});
  endtask

  task automatic t_reset();
    int v;
    busRead(4'd0, v); check("R1", "status after reset", v, 0);
    check("R1", "irq after reset", int'(irqReq), 0);
    busRead(4'd1, v); check("R1", "ien after reset", v, 0);
    busRead(4'd2, v); check("R1", "mode after reset", v, 0);
    busRead(4'd3, v); check("R12", "cmpA high reset", v, 8'hFF);
    busRead(4'd4, v); check("R12", "cmpA low reset", v, 8'hFF);
    busRead(4'd7, v); check("R12", "offset 7", v, 0);
    pulseCap(3);
    readCap(3, v); check("R1", "counter 0 seen by capture A", v, 0);
    busRead(4'd0, v); check("R5", "capture A flag", v, 8'h80);
    busWrite(4'd0, 8'h00);
    busRead(4'd0, v); check("R8", "flag cleared after read then 0", v, 0);
  endtask

  task automatic t_count();
    int v;
    tick(37);
    pulseCap(2);
    readCap(2, v); check("R2", "count after 37 ticks", v, expCnt);
    busRead(4'd0, v); check("R5", "capture B flag", v & 8'h40, 8'h40);
    repeat (10) @(negedge clk);
    pulseCap(2);
    readCap(2, v); check("R2", "count holds without tick", v, expCnt);
    clearFlags();
  endtask

  task automatic t_compare();
    int v, c;
    c = expCnt;
    writeCmp(1'b0, c + 4);
    tick(4);
    busRead(4'd0, v); check("R3", "cmpB flag before match tick", v & 8'h04, 0);
    tick(1);
    busRead(4'd0, v); check("R3", "cmpB flag at match tick", v & 8'h04, 8'h04);
    c = expCnt;
    writeCmp(1'b1, c + 2);
    tick(2);
    busRead(4'd0, v); check("R3", "cmpA flag before match tick", v & 8'h08, 0);
    tick(1);
    busRead(4'd0, v); check("R3", "cmpA flag at match tick", v & 8'h08, 8'h08);
    clearFlags();
    busRead(4'd5, v); check("R12", "cmpB high readback", v, 0);
    busRead(4'd6, v); check("R12", "cmpB low readback", v, 41);
  endtask

  task automatic t_overflow();
    int v;
    tick(MODV - 1 - expCnt);
    busRead(4'd0, v); check("R2", "no overflow at max", v & 8'h02, 0);
    tick(1);
    busRead(4'd0, v); check("R2", "overflow on wrap", v & 8'h02, 8'h02);
    pulseCap(1);
    readCap(1, v); check("R2", "counter zero after wrap", v, 0);
    clearFlags();
  endtask

  task automatic t_clear_on_a();
    int v;
    busWrite(4'd0, 8'hFF);
    cclrExp = 1'b1;
    busRead(4'd0, v); check("R7", "write ones sets only bit 0", v, 8'h01);
    writeCmp(1'b1, 3);
    tick(3);
    tick(1);
    expCnt = 0;
    busRead(4'd0, v); check("R4", "cmpA flag on clear", v & 8'h08, 8'h08);
    pulseCap(0);
    readCap(0, v); check("R4", "counter back to zero", v, 0);
    clearFlags();
    writeCmp(1'b1, MODV - 1);
    tick(MODV - 1);
    tick(1);
    expCnt = 0;
    busRead(4'd0, v); check("R4", "no overflow from clear at max", v & 8'h0A, 8'h08);
    pulseCap(3);
    readCap(3, v); check("R4", "cleared at max value", v, 0);
    busWrite(4'd0, 8'hFE);
    cclrExp = 1'b0;
    clearFlags();
  endtask

  task automatic t_buffer();
    int v;
    busWrite(4'd2, 8'h01);
    busRead(4'd2, v); check("R12", "mode readback", v, 1);
    tick(5);
    pulseCap(3);
    tick(6);
    pulseCap(3);
    readCap(3, v); check("R6", "buffered A new value", v, 11);
    readCap(1, v); check("R6", "buffered C holds old A", v, 5);
    busRead(4'd0, v); check("R6", "A flag set, C flag clear", v & 8'hA0, 8'h80);
    pulseCap(1);
    readCap(1, v); check("R6", "C input ignored in buffer mode", v, 5);
    busRead(4'd0, v); check("R6", "C flag stays clear", v & 8'h20, 0);
    busWrite(4'd2, 8'h00);
  endtask

  task automatic t_unbuf();
    int v;
    pulseCap(1);
    readCap(1, v); check("R5", "capture C unbuffered", v, expCnt);
    pulseCap(0);
    readCap(0, v); check("R5", "capture D", v, expCnt);
    busRead(4'd0, v); check("R5", "C and D flags", v & 8'h30, 8'h30);
    clearFlags();
  endtask

  task automatic t_protocol();
    int v;
    busWrite(4'd0, 8'hFE);
    pulseCap(0);
    busWrite(4'd0, 8'h00);
    busRead(4'd0, v); check("R8", "write 0 without read keeps flag", v & 8'h10, 8'h10);
    busWrite(4'd0, 8'hFE);
    busWrite(4'd0, 8'h00);
    busRead(4'd0, v); check("R8", "intervening write drops permission", v & 8'h10, 8'h10);
    busWrite(4'd0, 8'h00);
    busRead(4'd0, v); check("R8", "read then write 0 clears", v & 8'h10, 0);
  endtask

  task automatic t_hw_wins();
    int v;
    pulseCap(3);
    busRead(4'd0, v);
    @(negedge clk);
    capIn[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 4'd0; busWrData = 8'h00; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    repeat (3) @(negedge clk);
    capIn[3] = 1'b0;
    busRead(4'd0, v); check("R9", "set beats same-cycle clear", v & 8'h80, 8'h80);
  endtask

  task automatic t_standby();
    int v;
    busWrite(4'd0, 8'hFF);
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    busRead(4'd0, v); check("R10", "standby wipes status", v, 0);
  endtask

  task automatic t_irq();
    int v;
    clearFlags();
    busWrite(4'd1, 8'h00);
    tick(MODV - expCnt);
    check("R11", "no irq with enables off", int'(irqReq), 0);
    busWrite(4'd1, 8'h02);
    check("R11", "overflow irq on bit 0", int'(irqReq), 7'h01);
    busRead(4'd1, v); check("R12", "ien readback", v, 8'h02);
    busWrite(4'd1, 8'h83);
    busRead(4'd1, v); check("R12", "ien bit 0 reads 0", v, 8'h82);
    pulseCap(3);
    check("R11", "capture A irq on bit 6", int'(irqReq), 7'h41);
    clearFlags();
    check("R11", "irq drops with flags", int'(irqReq), 0);
  endtask

  initial begin
    rstN = 1'b0; standby = 1'b0; tickEn = 1'b0; capIn = '0;
    busAddr = '0; busRd = 1'b0; busWr = 1'b0; busWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_compare();
    t_overflow();
    t_clear_on_a();
    t_buffer();
    t_unbuf();
    t_protocol();
    t_hw_wins();
    t_standby();
    t_irq();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule